// File: doc/BRIEF.md
# Reference-Counted Register and Checkpoint Reclaim

This block frees physical registers without a reorder buffer. Each physical register has a saturating counter. Every rename reference to the register adds one, whether the register is a source or the freshly allocated destination. Every execute report that names the register subtracts one. A register goes back to the free pool once its counter is zero and no live mapping still points at it. A live mapping is the current logical-to-physical map or the saved map of any live checkpoint.

The block also keeps a ring of eight rename-map checkpoints. Rename asks for a new checkpoint only on a low-confidence branch. Each checkpoint counts the instructions renamed into its region that have not yet executed. The oldest checkpoint retires when that count is zero and a younger checkpoint exists.

On a mispredict, the map saved at the named checkpoint is restored and every younger checkpoint is discarded. Instructions squashed by the recovery still report through the execute port with a squash flag. This keeps the register counters exact without touching the region counts.

Top module: `rcr_reclaim`

## Requirements
- R1: After reset, physical registers 0 to NUM_LREGS-1 map logical registers 0 to NUM_LREGS-1 and are busy. Every higher register is free, so free_mask is 16'hFFF0 with the default parameters. Only checkpoint slot 0 is live, both ring pointers are 0, and cnt_err is 0.
- R2: An accepted rename with a destination receives the lowest-numbered free register on ren_dst_preg in the same cycle. That register is absent from free_mask after the clock edge. ren_src_preg gives the current mapping of ren_src_lreg, read before this cycle's destination write.
- R3: A register's counter gains one for each accepted rename reference and loses one for each execute report. A gain and a loss on the same register in the same cycle leave the counter unchanged.
- R4: A register with a zero counter that is unmapped in the current map and in every live checkpoint's saved map reappears in free_mask one clock edge after that condition first holds.
- R5: ckpt_req with an accepted rename makes slot youngest+1 (modulo 8) the youngest live checkpoint. That slot saves the map as it stood before this instruction, and the instruction counts in the new region.
- R6: When the oldest checkpoint's region count is zero and a younger checkpoint is live, the oldest pointer advances by one at the next clock edge.
- R7: With all eight slots live, ckpt_req on a rename raises ren_stall. No checkpoint, mapping or counter changes that cycle.
- R8: mp_vld restores the map saved at mp_ckpt, makes mp_ckpt the youngest checkpoint, clears that checkpoint's region count and stalls any rename in that cycle.
- R9: An execute report with ex_squash=1 decrements the named register counters and leaves every region count unchanged.
- R10: With the defaults, register counters hold 0 to 7 and region counters hold 0 to 15. A step above the maximum or below zero holds the counter at the limit and sets cnt_err, which stays set until reset.
- R11: With no free register, a rename that needs a destination stalls, while a rename without a destination is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_vld | input | 1 | A renamed instruction is presented |
| ren_dst_vld | input | 1 | The instruction writes a destination |
| ren_dst_lreg | input | 2 | Logical destination |
| ren_src_vld | input | 1 | The instruction reads a source |
| ren_src_lreg | input | 2 | Logical source |
| ckpt_req | input | 1 | Low-confidence branch: take a checkpoint with this instruction |
| ren_dst_preg | output | 4 | Physical register offered for the destination |
| ren_src_preg | output | 4 | Current mapping of the source |
| ren_stall | output | 1 | The presented instruction is not accepted this cycle |
| ex_vld | input | 1 | An execute report is presented |
| ex_squash | input | 1 | The reporting instruction was squashed by recovery |
| ex_dst_vld | input | 1 | Report names a destination register |
| ex_dst_preg | input | 4 | Destination register of the report |
| ex_src_vld | input | 1 | Report names a source register |
| ex_src_preg | input | 4 | Source register of the report |
| ex_ckpt | input | 3 | Checkpoint region of the reporting instruction |
| mp_vld | input | 1 | Mispredict recovery request |
| mp_ckpt | input | 3 | Checkpoint to recover to |
| free_mask | output | 16 | One bit per free physical register |
| ckpt_valid | output | 8 | One bit per live checkpoint slot |
| ckpt_oldest | output | 3 | Oldest live checkpoint |
| ckpt_youngest | output | 3 | Youngest live checkpoint |
| cnt_err | output | 1 | Sticky counter overflow or underflow |

## Verification
Two kinds of event can meet in one cycle. A rename reference and an execute report can hit the same register counter. A checkpoint request can arrive in the same cycle as the release of the oldest slot, or as a mispredict. The bench makes a source read and an execute report on one register coincide. The counter must then survive one more decrement but not two, so a single further report is the first that raises cnt_err. Recovery arrives together with a rename that wants a destination, and that rename must stall. A source read after recovery must return the restored mapping, and registers orphaned by the squash must come back only after their squashed readers drain.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;

  // Next value of a saturating counter after a signed step.
  function automatic int sat_next(input int cur, input int top, input int step);
    int raw;
    raw = cur + step;
    if (raw < 0) return 0;
    if (raw > top) return top;
    return raw;
  endfunction

  // Whether that step would leave the counter range.
  function automatic logic sat_err(input int cur, input int top, input int step);
    int raw;
    raw = cur + step;
    return (raw < 0) || (raw > top);
  endfunction

  // Ring distance from base to idx for a power-of-two ring.
  function automatic int ring_dist(input int idx, input int base, input int size);
    return (idx - base + size) % size;
  endfunction

endpackage

// File: rtl/rcr_ref_counters.sv
`timescale 1ns/1ps
module rcr_ref_counters
  import rcr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_a_vld,
  input  logic [IDX_W-1:0]   up_a_idx,
  input  logic               up_b_vld,
  input  logic [IDX_W-1:0]   up_b_idx,
  input  logic               dn_a_vld,
  input  logic [IDX_W-1:0]   dn_a_idx,
  input  logic               dn_b_vld,
  input  logic [IDX_W-1:0]   dn_b_idx,
  input  logic [ENTRIES-1:0] clr_mask,
  output logic [ENTRIES-1:0] zero_mask,
  output logic               err_any
);

  logic [ENTRIES-1:0] err_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [CNT_W-1:0] cnt_q;
    int               step;
    int               base;
    int               nxt;
    logic             bad;

    always_comb begin
      step = 0;
      if (up_a_vld && (up_a_idx == IDX_W'(i))) step = step + 1;
      if (up_b_vld && (up_b_idx == IDX_W'(i))) step = step + 1;
      if (!clr_mask[i]) begin
        if (dn_a_vld && (dn_a_idx == IDX_W'(i))) step = step - 1;
        if (dn_b_vld && (dn_b_idx == IDX_W'(i))) step = step - 1;
      end
      base = clr_mask[i] ? 0 : int'(cnt_q);
      nxt  = sat_next(base, CNT_MAX, step);
      bad  = sat_err(base, CNT_MAX, step);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= CNT_W'(nxt);
    end

    assign zero_mask[i] = (cnt_q == '0);
    assign err_vec[i]   = bad;
  end

  assign err_any = |err_vec;

endmodule

// File: rtl/rcr_free_list.sv
`timescale 1ns/1ps
module rcr_free_list #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_RSV   = 4,
  localparam int PW       = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [NUM_PREGS-1:0] zero_mask,
  input  logic [NUM_PREGS-1:0] pin_mask,
  output logic [NUM_PREGS-1:0] free_mask,
  output logic [PW-1:0]        pick_idx,
  output logic                 pick_ok,
  output logic [NUM_PREGS-1:0] reclaim_mask
);

  localparam logic [NUM_PREGS-1:0] RST_FREE =
    ~((NUM_PREGS'(1) << NUM_RSV) - NUM_PREGS'(1));

  logic [NUM_PREGS-1:0] free_q;
  logic [NUM_PREGS-1:0] take_mask;

  always_comb begin
    pick_idx = '0;
    pick_ok  = 1'b0;
    for (int i = NUM_PREGS - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        pick_idx = PW'(i);
        pick_ok  = 1'b1;
      end
    end
  end

  assign reclaim_mask = ~free_q & zero_mask & ~pin_mask;
  assign take_mask    = (take && pick_ok) ? (NUM_PREGS'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= RST_FREE;
    else        free_q <= (free_q & ~take_mask) | reclaim_mask;
  end

  assign free_mask = free_q;

endmodule

// File: rtl/rcr_map_state.sv
`timescale 1ns/1ps
module rcr_map_state #(
  parameter int NUM_LREGS = 4,
  parameter int NUM_PREGS = 16,
  localparam int LW = $clog2(NUM_LREGS),
  localparam int PW = $clog2(NUM_PREGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [LW-1:0]                  wr_lreg,
  input  logic [PW-1:0]                  wr_preg,
  input  logic                           restore,
  input  logic [NUM_LREGS-1:0][PW-1:0]   restore_map,
  input  logic [LW-1:0]                  rd_lreg,
  output logic [PW-1:0]                  rd_preg,
  output logic [NUM_LREGS-1:0][PW-1:0]   map_q,
  output logic [NUM_PREGS-1:0]           pin_mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LREGS; l++) map_q[l] <= PW'(l);
    end else if (restore) begin
      map_q <= restore_map;
    end else if (wr_en) begin
      map_q[wr_lreg] <= wr_preg;
    end
  end

  assign rd_preg = map_q[rd_lreg];

  always_comb begin
    pin_mask = '0;
    for (int l = 0; l < NUM_LREGS; l++) pin_mask[map_q[l]] = 1'b1;
  end

endmodule

// File: rtl/rcr_ckpt_table.sv
`timescale 1ns/1ps
module rcr_ckpt_table
  import rcr_pkg::*;
#(
  parameter int NUM_CKPT  = 8,
  parameter int NUM_LREGS = 4,
  parameter int NUM_PREGS = 16,
  localparam int CKW = $clog2(NUM_CKPT),
  localparam int PW  = $clog2(NUM_PREGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic [NUM_LREGS-1:0][PW-1:0] cur_map,
  input  logic                         recover,
  input  logic [CKW-1:0]               recover_id,
  input  logic [NUM_CKPT-1:0]          region_zero,
  output logic [NUM_CKPT-1:0]          valid_mask,
  output logic [CKW-1:0]               oldest,
  output logic [CKW-1:0]               youngest,
  output logic [CKW-1:0]               next_id,
  output logic                         full,
  output logic                         release_ev,
  output logic [NUM_LREGS-1:0][PW-1:0] restore_map,
  output logic [NUM_PREGS-1:0]         pin_mask
);

  logic [CKW-1:0]               old_q;
  logic [CKW-1:0]               young_q;
  logic [NUM_LREGS-1:0][PW-1:0] saved_q [NUM_CKPT];
  int                           span;

  assign span    = ring_dist(int'(young_q), int'(old_q), NUM_CKPT);
  assign full    = (span == NUM_CKPT - 1);
  assign next_id = young_q + CKW'(1);

  always_comb begin
    for (int i = 0; i < NUM_CKPT; i++)
      valid_mask[i] = ring_dist(i, int'(old_q), NUM_CKPT) <= span;
  end

  assign release_ev  = region_zero[old_q] && (old_q != young_q) && !recover;
  assign restore_map = saved_q[recover_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q   <= '0;
      young_q <= '0;
      for (int c = 0; c < NUM_CKPT; c++)
        for (int l = 0; l < NUM_LREGS; l++) saved_q[c][l] <= PW'(l);
    end else begin
      if (release_ev) old_q <= old_q + CKW'(1);
      if (recover) begin
        young_q <= recover_id;
      end else if (take) begin
        young_q          <= next_id;
        saved_q[next_id] <= cur_map;
      end
    end
  end

  always_comb begin
    pin_mask = '0;
    for (int c = 0; c < NUM_CKPT; c++)
      if (valid_mask[c])
        for (int l = 0; l < NUM_LREGS; l++) pin_mask[saved_q[c][l]] = 1'b1;
  end

  assign oldest   = old_q;
  assign youngest = young_q;

endmodule

// File: rtl/rcr_reclaim.sv
`timescale 1ns/1ps
module rcr_reclaim #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_LREGS = 4,
  parameter int NUM_CKPT  = 8,
  parameter int REG_CNT_W = 3,
  parameter int RGN_CNT_W = 4,
  localparam int PW  = $clog2(NUM_PREGS),
  localparam int LW  = $clog2(NUM_LREGS),
  localparam int CKW = $clog2(NUM_CKPT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ren_vld,
  input  logic                 ren_dst_vld,
  input  logic [LW-1:0]        ren_dst_lreg,
  input  logic                 ren_src_vld,
  input  logic [LW-1:0]        ren_src_lreg,
  input  logic                 ckpt_req,
  output logic [PW-1:0]        ren_dst_preg,
  output logic [PW-1:0]        ren_src_preg,
  output logic                 ren_stall,
  input  logic                 ex_vld,
  input  logic                 ex_squash,
  input  logic                 ex_dst_vld,
  input  logic [PW-1:0]        ex_dst_preg,
  input  logic                 ex_src_vld,
  input  logic [PW-1:0]        ex_src_preg,
  input  logic [CKW-1:0]       ex_ckpt,
  input  logic                 mp_vld,
  input  logic [CKW-1:0]       mp_ckpt,
  output logic [NUM_PREGS-1:0] free_mask,
  output logic [NUM_CKPT-1:0]  ckpt_valid,
  output logic [CKW-1:0]       ckpt_oldest,
  output logic [CKW-1:0]       ckpt_youngest,
  output logic                 cnt_err
);

  // Named internal events
  logic                         accept_ev;
  logic                         alloc_ev;
  logic                         take_ev;
  logic                         release_ev;
  logic                         full;
  logic                         pick_ok;
  logic [PW-1:0]                pick_idx;
  logic [CKW-1:0]               next_id;
  logic [CKW-1:0]               rgn_id;
  logic [NUM_PREGS-1:0]         reg_zero;
  logic [NUM_PREGS-1:0]         map_pin;
  logic [NUM_PREGS-1:0]         ckpt_pin;
  logic [NUM_PREGS-1:0]         reclaim_mask;
  logic [NUM_CKPT-1:0]          rgn_zero;
  logic [NUM_CKPT-1:0]          rgn_clr;
  logic [NUM_LREGS-1:0][PW-1:0] cur_map;
  logic [NUM_LREGS-1:0][PW-1:0] restore_map;
  logic                         reg_err;
  logic                         rgn_err;
  logic                         err_q;

  assign ren_stall = ren_vld && (mp_vld || (ckpt_req && full) || (ren_dst_vld && !pick_ok));
  assign accept_ev = ren_vld && !ren_stall;
  assign alloc_ev  = accept_ev && ren_dst_vld;
  assign take_ev   = accept_ev && ckpt_req;
  assign rgn_id    = take_ev ? next_id : ckpt_youngest;

  always_comb begin
    rgn_clr = '0;
    if (mp_vld)       rgn_clr[mp_ckpt] = 1'b1;
    else if (take_ev) rgn_clr[next_id] = 1'b1;
  end

  rcr_map_state #(
    .NUM_LREGS(NUM_LREGS), .NUM_PREGS(NUM_PREGS)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_ev), .wr_lreg(ren_dst_lreg), .wr_preg(pick_idx),
    .restore(mp_vld), .restore_map(restore_map),
    .rd_lreg(ren_src_lreg), .rd_preg(ren_src_preg),
    .map_q(cur_map), .pin_mask(map_pin)
  );

  rcr_ckpt_table #(
    .NUM_CKPT(NUM_CKPT), .NUM_LREGS(NUM_LREGS), .NUM_PREGS(NUM_PREGS)
  ) u_ckpt (
    .clk(clk), .rst_n(rst_n),
    .take(take_ev), .cur_map(cur_map),
    .recover(mp_vld), .recover_id(mp_ckpt),
    .region_zero(rgn_zero),
    .valid_mask(ckpt_valid), .oldest(ckpt_oldest), .youngest(ckpt_youngest),
    .next_id(next_id), .full(full), .release_ev(release_ev),
    .restore_map(restore_map), .pin_mask(ckpt_pin)
  );

  rcr_ref_counters #(
    .ENTRIES(NUM_PREGS), .CNT_W(REG_CNT_W)
  ) u_reg_cnt (
    .clk(clk), .rst_n(rst_n),
    .up_a_vld(alloc_ev), .up_a_idx(pick_idx),
    .up_b_vld(accept_ev && ren_src_vld), .up_b_idx(ren_src_preg),
    .dn_a_vld(ex_vld && ex_dst_vld), .dn_a_idx(ex_dst_preg),
    .dn_b_vld(ex_vld && ex_src_vld), .dn_b_idx(ex_src_preg),
    .clr_mask('0),
    .zero_mask(reg_zero), .err_any(reg_err)
  );

  rcr_ref_counters #(
    .ENTRIES(NUM_CKPT), .CNT_W(RGN_CNT_W)
  ) u_rgn_cnt (
    .clk(clk), .rst_n(rst_n),
    .up_a_vld(accept_ev), .up_a_idx(rgn_id),
    .up_b_vld(1'b0), .up_b_idx('0),
    .dn_a_vld(ex_vld && !ex_squash), .dn_a_idx(ex_ckpt),
    .dn_b_vld(1'b0), .dn_b_idx('0),
    .clr_mask(rgn_clr),
    .zero_mask(rgn_zero), .err_any(rgn_err)
  );

  rcr_free_list #(
    .NUM_PREGS(NUM_PREGS), .NUM_RSV(NUM_LREGS)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .take(alloc_ev), .zero_mask(reg_zero), .pin_mask(map_pin | ckpt_pin),
    .free_mask(free_mask), .pick_idx(pick_idx), .pick_ok(pick_ok),
    .reclaim_mask(reclaim_mask)
  );

  assign ren_dst_preg = pick_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q || reg_err || rgn_err;
  end

  assign cnt_err = err_q;

endmodule

// File: rtl/rcr_reclaim_chk.sv
`timescale 1ns/1ps
module rcr_reclaim_chk #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_CKPT  = 8,
  localparam int PW  = $clog2(NUM_PREGS),
  localparam int CKW = $clog2(NUM_CKPT)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ren_vld,
  input logic                 ckpt_req,
  input logic                 ren_stall,
  input logic                 mp_vld,
  input logic [CKW-1:0]       mp_ckpt,
  input logic [PW-1:0]        ren_dst_preg,
  input logic [NUM_PREGS-1:0] free_mask,
  input logic [NUM_CKPT-1:0]  ckpt_valid,
  input logic [CKW-1:0]       ckpt_oldest,
  input logic [CKW-1:0]       ckpt_youngest,
  input logic                 cnt_err,
  input logic                 alloc_ev,
  input logic                 release_ev,
  input logic                 full,
  input logic [NUM_PREGS-1:0] reclaim_mask
);

  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |-> free_mask[ren_dst_preg]); // R2
  AST_ALLOC_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |=> !free_mask[$past(ren_dst_preg)]); // R2
  AST_RECLAIM_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reclaim_mask != '0) |=> ((free_mask & $past(reclaim_mask)) == $past(reclaim_mask))); // R4
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_vld && ckpt_req && full) |-> ren_stall); // R7
  AST_FULL_HOLDS_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_vld && ckpt_req && full && !mp_vld) |=> $stable(ckpt_youngest)); // R7
  AST_MP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_vld && ren_vld) |-> ren_stall); // R8
  AST_MP_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
    mp_vld |=> (ckpt_youngest == $past(mp_ckpt))); // R8
  AST_OLDEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (ckpt_oldest == CKW'($past(ckpt_oldest) + 1'b1))); // R6
  AST_ENDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_valid[ckpt_oldest] && ckpt_valid[ckpt_youngest]); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err); // R10

endmodule

bind rcr_reclaim rcr_reclaim_chk #(
  .NUM_PREGS(NUM_PREGS), .NUM_CKPT(NUM_CKPT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_vld(ren_vld), .ckpt_req(ckpt_req),
  .ren_stall(ren_stall), .mp_vld(mp_vld), .mp_ckpt(mp_ckpt),
  .ren_dst_preg(ren_dst_preg), .free_mask(free_mask), .ckpt_valid(ckpt_valid),
  .ckpt_oldest(ckpt_oldest), .ckpt_youngest(ckpt_youngest), .cnt_err(cnt_err),
  .alloc_ev(alloc_ev), .release_ev(release_ev), .full(full),
  .reclaim_mask(reclaim_mask)
);

// File: tb/rcr_reclaim_tb.sv
`timescale 1ns/1ps
module rcr_reclaim_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ren_vld = 0, ren_dst_vld = 0, ren_src_vld = 0, ckpt_req = 0;
  logic [1:0]  ren_dst_lreg = 0, ren_src_lreg = 0;
  logic [3:0]  ren_dst_preg, ren_src_preg;
  logic        ren_stall;
  logic        ex_vld = 0, ex_squash = 0, ex_dst_vld = 0, ex_src_vld = 0;
  logic [3:0]  ex_dst_preg = 0, ex_src_preg = 0;
  logic [2:0]  ex_ckpt = 0, mp_ckpt = 0;
  logic        mp_vld = 0;
  logic [15:0] free_mask;
  logic [7:0]  ckpt_valid;
  logic [2:0]  ckpt_oldest, ckpt_youngest;
  logic        cnt_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  rcr_reclaim u_dut (
    .clk(clk), .rst_n(rst_n),
    .ren_vld(ren_vld), .ren_dst_vld(ren_dst_vld), .ren_dst_lreg(ren_dst_lreg),
    .ren_src_vld(ren_src_vld), .ren_src_lreg(ren_src_lreg), .ckpt_req(ckpt_req),
    .ren_dst_preg(ren_dst_preg), .ren_src_preg(ren_src_preg), .ren_stall(ren_stall),
    .ex_vld(ex_vld), .ex_squash(ex_squash), .ex_dst_vld(ex_dst_vld),
    .ex_dst_preg(ex_dst_preg), .ex_src_vld(ex_src_vld), .ex_src_preg(ex_src_preg),
    .ex_ckpt(ex_ckpt), .mp_vld(mp_vld), .mp_ckpt(mp_ckpt),
    .free_mask(free_mask), .ckpt_valid(ckpt_valid), .ckpt_oldest(ckpt_oldest),
    .ckpt_youngest(ckpt_youngest), .cnt_err(cnt_err)
  );

  typedef struct packed {
    logic rv; logic ck; logic dv; logic [1:0] dl; logic sv; logic [1:0] sl;
    logic xv; logic xq; logic xdv; logic [3:0] xdp; logic xsv; logic [3:0] xsp; logic [2:0] xc;
    logic mv; logic [2:0] mc;
    logic [3:0] e_dst; logic [3:0] e_src; logic e_stall;
    logic [15:0] e_free; logic [2:0] e_young; logic [7:0] e_valid;
  } vec_t;

  localparam int NV = 11;
  // rv ck dv dl sv sl | xv xq xdv xdp xsv xsp xc | mv mc | dst src stall free young valid
  localparam vec_t VECS [NV] = '{
    '{1,0,1,0,1,1, 0,0,0,0,0,0,0, 0,0, 4,1,0, 16'hFFE0, 0, 8'h01}, // R2 R3
    '{1,1,0,0,1,0, 0,0,0,0,0,0,0, 0,0, 5,4,0, 16'hFFE0, 1, 8'h03}, // R5
    '{1,0,1,0,0,0, 1,0,1,4,1,1,0, 0,0, 5,0,0, 16'hFFC0, 1, 8'h03}, // R2 R3
    '{0,0,0,0,0,0, 0,0,0,0,0,0,0, 0,0, 6,0,0, 16'hFFC0, 1, 8'h02}, // R6
    '{0,0,0,0,0,0, 0,0,0,0,0,0,0, 0,0, 6,0,0, 16'hFFC1, 1, 8'h02}, // R4
    '{1,0,1,1,1,0, 1,0,0,0,1,4,1, 0,0, 0,5,0, 16'hFFC0, 1, 8'h02}, // R2
    '{1,0,1,2,0,0, 0,0,0,0,0,0,0, 1,1, 6,0,1, 16'hFFC0, 1, 8'h02}, // R8
    '{0,0,0,0,0,0, 1,1,1,5,0,0,1, 0,0, 6,0,0, 16'hFFC0, 1, 8'h02}, // R9
    '{0,0,0,0,0,0, 1,1,1,0,1,5,1, 0,0, 6,0,0, 16'hFFC0, 1, 8'h02}, // R9
    '{0,0,0,0,0,0, 0,0,0,0,0,0,0, 0,0, 6,0,0, 16'hFFE1, 1, 8'h02}, // R4
    '{1,0,1,0,1,0, 0,0,0,0,0,0,0, 0,0, 0,4,0, 16'hFFE0, 1, 8'h02}  // R8 restore
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ren_vld = 0; ren_dst_vld = 0; ren_src_vld = 0; ckpt_req = 0;
    ren_dst_lreg = 0; ren_src_lreg = 0;
    ex_vld = 0; ex_squash = 0; ex_dst_vld = 0; ex_src_vld = 0;
    ex_dst_preg = 0; ex_src_preg = 0; ex_ckpt = 0; mp_vld = 0; mp_ckpt = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic rename(input logic dv, input logic [1:0] dl, input logic sv,
                        input logic [1:0] sl, input logic ck);
    ren_vld = 1; ren_dst_vld = dv; ren_dst_lreg = dl;
    ren_src_vld = sv; ren_src_lreg = sl; ckpt_req = ck;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1", "free_mask", int'(free_mask), 16'hFFF0);
    check("R1", "ckpt_valid", int'(ckpt_valid), 8'h01);
    check("R1", "oldest", int'(ckpt_oldest), 0);
    check("R1", "youngest", int'(ckpt_youngest), 0);
    check("R1", "cnt_err", int'(cnt_err), 0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ren_vld = VECS[v].rv; ckpt_req = VECS[v].ck;
      ren_dst_vld = VECS[v].dv; ren_dst_lreg = VECS[v].dl;
      ren_src_vld = VECS[v].sv; ren_src_lreg = VECS[v].sl;
      ex_vld = VECS[v].xv; ex_squash = VECS[v].xq;
      ex_dst_vld = VECS[v].xdv; ex_dst_preg = VECS[v].xdp;
      ex_src_vld = VECS[v].xsv; ex_src_preg = VECS[v].xsp; ex_ckpt = VECS[v].xc;
      mp_vld = VECS[v].mv; mp_ckpt = VECS[v].mc;
      #1;
      if (VECS[v].dv) check("R2", $sformatf("vec%0d dst", v), int'(ren_dst_preg), int'(VECS[v].e_dst));
      if (VECS[v].sv) check("R2", $sformatf("vec%0d src", v), int'(ren_src_preg), int'(VECS[v].e_src));
      check("R8", $sformatf("vec%0d stall", v), int'(ren_stall), int'(VECS[v].e_stall));
      @(posedge clk); #1;
      check("R4", $sformatf("vec%0d free", v), int'(free_mask), int'(VECS[v].e_free));
      check("R5", $sformatf("vec%0d young", v), int'(ckpt_youngest), int'(VECS[v].e_young));
      check("R6", $sformatf("vec%0d valid", v), int'(ckpt_valid), int'(VECS[v].e_valid));
      idle_inputs();
    end
    check("R9", "no region underflow after squash drains", int'(cnt_err), 0);

    // R7: fill all eight checkpoints, then one more request
    do_reset();
    rename(0, 0, 1, 0, 0); tick();
    for (int k = 0; k < 7; k++) begin rename(0, 0, 1, 0, 1); tick(); end
    idle_inputs();
    #1;
    check("R7", "all slots live", int'(ckpt_valid), 8'hFF);
    check("R7", "youngest at 7", int'(ckpt_youngest), 7);
    rename(1, 1, 0, 0, 1);
    #1;
    check("R7", "full request stalls", int'(ren_stall), 1);
    @(posedge clk); #1;
    check("R7", "youngest unchanged", int'(ckpt_youngest), 7);
    check("R7", "no register taken", int'(free_mask), 16'hFFF0);
    @(negedge clk); idle_inputs();
    // R6: drain region 0, oldest advances one edge later
    ex_vld = 1; ex_ckpt = 0; tick(); idle_inputs();
    check("R6", "oldest not yet moved", int'(ckpt_oldest), 0);
    tick();
    check("R6", "oldest advanced", int'(ckpt_oldest), 1);
    rename(0, 0, 0, 0, 1);
    #1;
    check("R5", "request after release accepted", int'(ren_stall), 0);
    tick(); idle_inputs();
    check("R5", "youngest wraps to 0", int'(ckpt_youngest), 0);
    check("R5", "all slots live again", int'(ckpt_valid), 8'hFF);

    // R11: exhaust the free pool
    do_reset();
    for (int k = 0; k < 12; k++) begin rename(1, 3, 0, 0, 0); tick(); end
    idle_inputs();
    check("R11", "pool empty", int'(free_mask), 0);
    rename(1, 2, 0, 0, 0);
    #1;
    check("R11", "destination rename stalls", int'(ren_stall), 1);
    rename(0, 0, 1, 3, 0);
    #1;
    check("R11", "sourceless-dst rename accepted", int'(ren_stall), 0);
    check("R2", "src sees last mapping", int'(ren_src_preg), 15);
    tick(); idle_inputs();

    // R10: overflow of a register counter
    do_reset();
    for (int k = 0; k < 7; k++) begin rename(0, 0, 1, 2, 0); tick(); end
    idle_inputs();
    check("R10", "no error at max", int'(cnt_err), 0);
    rename(0, 0, 1, 2, 0); tick(); idle_inputs();
    check("R10", "overflow flags", int'(cnt_err), 1);
    tick();
    check("R10", "flag sticky", int'(cnt_err), 1);

    // R3: same-cycle increment and decrement cancel; R10 underflow
    do_reset();
    rename(0, 0, 1, 1, 0); tick(); idle_inputs();
    rename(0, 0, 1, 1, 0); ex_vld = 1; ex_squash = 1; ex_src_vld = 1; ex_src_preg = 1;
    tick(); idle_inputs();
    ex_vld = 1; ex_squash = 1; ex_src_vld = 1; ex_src_preg = 1; tick(); idle_inputs();
    check("R3", "count was one, reaches zero cleanly", int'(cnt_err), 0);
    ex_vld = 1; ex_squash = 1; ex_src_vld = 1; ex_src_preg = 1; tick(); idle_inputs();
    check("R10", "underflow flags", int'(cnt_err), 1);
    check("R3", "pinned register not freed", int'(free_mask), 16'hFFF0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule